// File: doc/BRIEF.md
# Loop Divider Pair with Lock Detection

This block holds the digital counting section of a frequency synthesizer loop. One chain divides the prescaled RF clock by a 15-bit programmable ratio; the other divides the crystal clock by one of three fixed ratios (512, 640 or 1024), picked by a 2-bit code. Each chain emits a one-cycle comparison pulse at its terminal count. A phase/frequency detector turns the order of those pulses into pump-up and pump-down requests, and a lock detector watches how far apart the pulses land.

Both source clocks arrive as single-cycle enable strobes (`rf_tick`, `ref_tick`) already synchronised to the block clock, so everything runs in one clock domain. A counter takes a new ratio only when it reloads at terminal count, so a ratio written mid-period never produces a short or long period. Control inputs can silence the pump outputs, shut off the loop drive, or route both divided pulses to two port outputs for production test.

Top module: `pll_divider_pair`

## Requirements
- R1: `rf_pulse` fires once for every `prog_ratio` RF ticks, where `prog_ratio` is the plain binary count (valid range 256 to 32767).
- R2: `ref_pulse` fires once per N reference ticks, where N is 640 when `ref_sel[0]`=0 (bit 1 ignored), 1024 when `ref_sel`=2'b01, and 512 when `ref_sel`=2'b11.
- R3: Each comparison pulse is high for exactly one clock, in the cycle after the clock edge that sampled the terminal tick; the first tick after reset is a terminal tick.
- R4: A ratio change takes effect only at the next reload; the period already running finishes with the old ratio.
- R5: `pump_up` is raised while a reference pulse waits for its RF pulse, `pump_dn` while an RF pulse waits for its reference pulse; both clear when the pair is complete, and they are never high together.
- R6: `lock` goes to 1 after 4 consecutive comparison pairs whose spacing is at most one reference tick, and drops to 0 as soon as a pending pair reaches a spacing of two reference ticks.
- R7: While `pump_off` is 1, `pump_up` and `pump_dn` stay 0 and `pump_tristate` is 1.
- R8: While `drive_off` is 1, `drive_en` is 0, both pump outputs stay 0 and `pump_tristate` is 1.
- R9: With `test_route`=1, `port1_out` follows `ref_pulse` and `port2_out` follows `rf_pulse`; with 0 they follow `port1_level` and `port2_level`.
- R10: After reset both pulses, both pump outputs and `lock` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_tick | input | 1 | One-cycle strobe per prescaled RF clock edge |
| ref_tick | input | 1 | One-cycle strobe per crystal clock edge |
| prog_ratio | input | 15 | Programmable RF division ratio |
| ref_sel | input | 2 | Reference ratio code |
| test_route | input | 1 | Route divided pulses to the port outputs |
| pump_off | input | 1 | Silence the pump requests |
| drive_off | input | 1 | Disable the loop drive |
| port1_level | input | 1 | Register value for port 1 |
| port2_level | input | 1 | Register value for port 2 |
| rf_pulse | output | 1 | Divided RF comparison pulse |
| ref_pulse | output | 1 | Divided reference comparison pulse |
| pump_up | output | 1 | Raise-frequency request |
| pump_dn | output | 1 | Lower-frequency request |
| pump_tristate | output | 1 | Pump held in high-impedance state |
| drive_en | output | 1 | Loop drive enabled |
| lock | output | 1 | Loop in lock |
| port1_out | output | 1 | Port 1 level |
| port2_out | output | 1 | Port 2 level |

## Verification
The single-pulse property of the dividers assumes ratios of at least two, which the stimulus respects by drawing programmable ratios from 256 upward and using only the three fixed reference ratios. The lock and detector properties assume that ticks are clean one-cycle strobes; the bench drives them on the falling edge, with random densities for the divider checks and with both strobes every cycle for the lock sequences, where phase offsets of one and two ticks are made by stretching or shortening a single RF period.

// File: rtl/pll_div_pkg.sv
// Shared widths and the reference ratio decode for the divider pair.
// Assumes the caller feeds a 2-bit ratio code; every code maps to a ratio.
package pll_div_pkg;
    localparam int PROG_W = 15;
    localparam int REF_W  = 11;

    // Decode the reference code: bit 0 low picks 640, else bit 1 picks 512/1024.
    function automatic logic [REF_W-1:0] ref_ratio(input logic [1:0] code);
        if (!code[0])
            return REF_W'(640);
        else if (!code[1])
            return REF_W'(1024);
        else
            return REF_W'(512);
    endfunction
endpackage

// File: rtl/pll_tick_divider.sv
// Down counter that divides a tick strobe by a ratio and emits one-cycle
// pulses at terminal count. The ratio is sampled only on reload, so a change
// never alters the period in progress. Assumes ratio >= 2 for single pulses.
module pll_tick_divider #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         pulse
);
    logic [W-1:0] cnt;

    // Count ticks down; reload and pulse on the terminal tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            if (tick) begin
                if (cnt < W'(2)) begin
                    cnt   <= ratio;
                    pulse <= 1'b1;
                end else begin
                    cnt <= cnt - W'(1);
                end
            end
        end
    end

    assert_pulse_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(tick));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse && $past(ratio) >= W'(2)) |=> !pulse);
endmodule

// File: rtl/pll_phase_lock.sv
// Phase/frequency detector plus lock detector. Up is held from a reference
// pulse until the matching RF pulse, down the other way round; a completed
// pair clears both. The spacing of each pair is measured in reference ticks.
// Assumes the comparison pulses are single-cycle.
module pll_phase_lock #(
    parameter int LOCK_PAIRS = 4,
    parameter int MAX_GAP    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_tick,
    input  logic ref_pulse,
    input  logic rf_pulse,
    output logic up,
    output logic dn,
    output logic locked
);
    localparam int GAP_W  = $clog2(MAX_GAP + 2) + 1;
    localparam int GOOD_W = $clog2(LOCK_PAIRS + 1);
    localparam logic [GAP_W-1:0] GAP_SAT = {GAP_W{1'b1}};

    logic [GAP_W-1:0]  gap, gap_now;
    logic [GOOD_W-1:0] good;
    logic              up_n, dn_n, pair_done, pending, too_far;

    // Next detector state, pair completion and current spacing.
    always_comb begin
        up_n      = up | ref_pulse;
        dn_n      = dn | rf_pulse;
        pair_done = up_n & dn_n;
        pending   = up | dn;
        gap_now   = gap;
        if (pending && ref_tick && gap != GAP_SAT)
            gap_now = gap + GAP_W'(1);
        too_far   = gap_now > GAP_W'(MAX_GAP);
    end

    // Detector flags, spacing counter and consecutive-good-pair counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up     <= 1'b0;
            dn     <= 1'b0;
            gap    <= '0;
            good   <= '0;
            locked <= 1'b0;
        end else if (pair_done) begin
            up  <= 1'b0;
            dn  <= 1'b0;
            gap <= '0;
            if (!too_far) begin
                if (good < GOOD_W'(LOCK_PAIRS))
                    good <= good + GOOD_W'(1);
                if (good + GOOD_W'(1) >= GOOD_W'(LOCK_PAIRS))
                    locked <= 1'b1;
            end else begin
                good   <= '0;
                locked <= 1'b0;
            end
        end else begin
            up  <= up_n;
            dn  <= dn_n;
            gap <= gap_now;
            if (too_far) begin
                good   <= '0;
                locked <= 1'b0;
            end
        end
    end

    assert_pfd_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

    assert_lock_on_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(up || ref_pulse) && $past(dn || rf_pulse)));

    assert_unlock_while_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(up || dn));
endmodule

// File: rtl/pll_divider_pair.sv
// Top of the divider section: programmable RF divider, selectable reference
// divider, detector/lock logic, pump gating and the test routing of the
// divided pulses onto two port outputs. Assumes both tick inputs are
// synchronous one-cycle strobes.
module pll_divider_pair
    import pll_div_pkg::*;
#(
    parameter int LOCK_PAIRS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rf_tick,
    input  logic              ref_tick,
    input  logic [PROG_W-1:0] prog_ratio,
    input  logic [1:0]        ref_sel,
    input  logic              test_route,
    input  logic              pump_off,
    input  logic              drive_off,
    input  logic              port1_level,
    input  logic              port2_level,
    output logic              rf_pulse,
    output logic              ref_pulse,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              pump_tristate,
    output logic              drive_en,
    output logic              lock,
    output logic              port1_out,
    output logic              port2_out
);
    logic [REF_W-1:0] ref_div;
    logic             up_raw, dn_raw;

    // Ratio for the reference chain from the selection code.
    always_comb ref_div = ref_ratio(ref_sel);

    pll_tick_divider #(.W(PROG_W)) i_rf_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (rf_tick),
        .ratio (prog_ratio),
        .pulse (rf_pulse)
    );

    pll_tick_divider #(.W(REF_W)) i_ref_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .ratio (ref_div),
        .pulse (ref_pulse)
    );

    pll_phase_lock #(.LOCK_PAIRS(LOCK_PAIRS), .MAX_GAP(1)) i_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .ref_pulse (ref_pulse),
        .rf_pulse  (rf_pulse),
        .up        (up_raw),
        .dn        (dn_raw),
        .locked    (lock)
    );

    // Pump gating by the disable controls and port output selection.
    always_comb begin
        pump_tristate = pump_off | drive_off;
        drive_en      = ~drive_off;
        pump_up       = up_raw & ~pump_tristate;
        pump_dn       = dn_raw & ~pump_tristate;
        port1_out     = test_route ? ref_pulse : port1_level;
        port2_out     = test_route ? rf_pulse  : port2_level;
    end

    always_comb begin
        if (rst_n && pump_off)
            assert_pump_quiet_R7: assert (!pump_up && !pump_dn && pump_tristate);
        if (rst_n && drive_off)
            assert_drive_quiet_R8: assert (!drive_en && !pump_up && !pump_dn);
    end
endmodule

// File: tb/test_pll_divider_pair.sv
module test_pll_divider_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rf_tick = 1'b0, ref_tick = 1'b0;
    logic [14:0] prog_ratio = 15'd512;
    logic [1:0]  ref_sel = 2'b11;
    logic        test_route = 1'b0, pump_off = 1'b0, drive_off = 1'b0;
    logic        port1_level = 1'b0, port2_level = 1'b0;
    logic        rf_pulse, ref_pulse, pump_up, pump_dn, pump_tristate;
    logic        drive_en, lock, port1_out, port2_out;

    int checks = 0, errors = 0;
    bit done = 0;
    int rf_cnt = 0, ref_cnt = 0, rf_exp = 0, ref_exp = 0;
    bit rf_armed = 0, ref_armed = 0;
    int up_cyc = 0, dn_cyc = 0, unlock_cyc = 0, tri_low = 0, route_bad = 0;

    always #10 clk = ~clk;

    pll_divider_pair i_pll_divider_pair (
        .clk(clk), .rst_n(rst_n), .rf_tick(rf_tick), .ref_tick(ref_tick),
        .prog_ratio(prog_ratio), .ref_sel(ref_sel), .test_route(test_route),
        .pump_off(pump_off), .drive_off(drive_off), .port1_level(port1_level),
        .port2_level(port2_level), .rf_pulse(rf_pulse), .ref_pulse(ref_pulse),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_tristate(pump_tristate),
        .drive_en(drive_en), .lock(lock), .port1_out(port1_out), .port2_out(port2_out)
    );

    function automatic int exp_ref(input logic [1:0] s);
        if (s[0] == 1'b0) return 640;
        if (s[1] == 1'b0) return 1024;
        return 512;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        up_cyc = 0; dn_cyc = 0; unlock_cyc = 0; tri_low = 0; route_bad = 0;
    endtask

    // One clock: drive strobes on the falling edge, observe after the rising edge.
    task automatic cyc(input bit rt, input bit ft);
        @(negedge clk);
        ref_tick = rt;
        rf_tick  = ft;
        @(posedge clk);
        #1;
        if (ft) rf_cnt++;
        if (rt) ref_cnt++;
        if (rf_pulse) begin
            if (rf_armed) chk(rf_cnt == rf_exp, "R1", "rf period", rf_cnt, rf_exp);
            rf_armed = 1; rf_exp = int'(prog_ratio); rf_cnt = 0;
        end
        if (ref_pulse) begin
            if (ref_armed) chk(ref_cnt == ref_exp, "R2", "ref period", ref_cnt, ref_exp);
            ref_armed = 1; ref_exp = exp_ref(ref_sel); ref_cnt = 0;
        end
        if (pump_up) up_cyc++;
        if (pump_dn) dn_cyc++;
        if (!lock) unlock_cyc++;
        if (!pump_tristate) tri_low++;
        if (test_route && (port1_out != ref_pulse || port2_out != rf_pulse)) route_bad++;
        if (!test_route && (port1_out != port1_level || port2_out != port2_level)) route_bad++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rf_tick = 1'b0; ref_tick = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rf_armed = 0; ref_armed = 0; rf_cnt = 0; ref_cnt = 0;
    endtask

    task automatic wait_rf_pulse();
        do cyc(1, 1); while (!rf_pulse);
    endtask

    // Stretch or shorten exactly one RF period, then return to 512.
    task automatic one_period(input int r);
        wait_rf_pulse();
        prog_ratio = 15'(r);
        wait_rf_pulse();
        prog_ratio = 15'd512;
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R10: reset state
        do_reset();
        #1;
        chk(!rf_pulse && !ref_pulse, "R10", "pulses after reset", {rf_pulse, ref_pulse}, 0);
        chk(!pump_up && !pump_dn, "R10", "pump after reset", {pump_up, pump_dn}, 0);
        chk(!lock, "R10", "lock after reset", lock, 0);
        // R3: first tick pulses, then single-cycle
        cyc(1, 1);
        chk(rf_pulse && ref_pulse, "R3", "first tick pulse", {rf_pulse, ref_pulse}, 3);
        cyc(1, 1);
        chk(!rf_pulse && !ref_pulse, "R3", "pulse width one", {rf_pulse, ref_pulse}, 0);

        // R1/R2: random ratios, codes and tick densities, changes mid-period (R4)
        for (int i = 0; i < 9000; i++) begin
            if (i % 700 == 350) begin
                prog_ratio = 15'($urandom_range(700, 256));
                ref_sel    = 2'($urandom_range(3, 0));
            end
            cyc(($urandom_range(1, 0) == 1), ($urandom_range(3, 0) != 0));
        end

        // R4: explicit mid-period change, ticks every cycle
        prog_ratio = 15'd300;
        wait_rf_pulse();
        wait_rf_pulse();
        begin
            int n = 0;
            repeat (100) cyc(1, 1);
            n = 100;
            prog_ratio = 15'd500;
            do begin cyc(1, 1); n++; end while (!rf_pulse);
            chk(n == 300, "R4", "period after mid change", n, 300);
            n = 0;
            do begin cyc(1, 1); n++; end while (!rf_pulse);
            chk(n == 500, "R4", "period using new ratio", n, 500);
        end

        // R1: minimum and maximum ratios; R2: each code directed
        prog_ratio = 15'd256;
        repeat (800) cyc(1, 1);
        prog_ratio = 15'd32767;
        for (int s = 0; s < 4; s++) begin
            ref_sel = 2'(s);
            repeat (16500) cyc(1, 1);
        end
        prog_ratio = 15'd512;
        repeat (33000) cyc(1, 1);

        // R9: test routing and register levels
        do_reset();
        prog_ratio = 15'd256; ref_sel = 2'b11;
        test_route = 1'b1; clear_counts();
        repeat (1200) cyc(($urandom_range(1, 0) == 1), 1);
        chk(route_bad == 0, "R9", "routed pulses", route_bad, 0);
        test_route = 1'b0; port1_level = 1'b1; port2_level = 1'b0; clear_counts();
        repeat (600) cyc(1, 1);
        chk(route_bad == 0, "R9", "register levels", route_bad, 0);

        // R6: acquire lock with aligned chains
        do_reset();
        prog_ratio = 15'd512; ref_sel = 2'b11;
        wait_rf_pulse(); wait_rf_pulse(); wait_rf_pulse();
        repeat (10) cyc(1, 1);
        chk(!lock, "R6", "no lock after 3 pairs", lock, 0);
        wait_rf_pulse();
        cyc(1, 1); cyc(1, 1);
        chk(lock, "R6", "lock after 4 pairs", lock, 1);

        // R5/R6: RF lags by one tick: up pulses, lock held
        clear_counts();
        one_period(513);
        repeat (1100) cyc(1, 1);
        chk(up_cyc > 0, "R5", "up when ref leads", up_cyc, 1);
        chk(dn_cyc == 0, "R5", "no down when ref leads", dn_cyc, 0);
        chk(unlock_cyc == 0, "R6", "lock kept at gap one", unlock_cyc, 0);

        // R7: pump disable
        pump_off = 1'b1; clear_counts();
        repeat (1100) cyc(1, 1);
        chk(up_cyc == 0 && dn_cyc == 0, "R7", "pump silent", up_cyc + dn_cyc, 0);
        chk(tri_low == 0, "R7", "tristate held", tri_low, 0);
        pump_off = 1'b0;

        // R8: drive disable
        drive_off = 1'b1; clear_counts();
        repeat (1100) cyc(1, 1);
        chk(!drive_en, "R8", "drive disabled", drive_en, 0);
        chk(up_cyc == 0 && dn_cyc == 0 && tri_low == 0, "R8", "pump silent",
            up_cyc + dn_cyc + tri_low, 0);
        drive_off = 1'b0;
        cyc(1, 1);
        chk(drive_en, "R8", "drive re-enabled", drive_en, 1);

        // R5: RF leads by one tick: down pulses
        one_period(511);
        one_period(511);
        clear_counts();
        repeat (1100) cyc(1, 1);
        chk(dn_cyc > 0 && up_cyc == 0, "R5", "down when rf leads", dn_cyc, 1);
        chk(unlock_cyc == 0, "R6", "lock kept when rf leads by one", unlock_cyc, 0);

        // R6: gap of two drops lock
        one_period(515);
        repeat (600) cyc(1, 1);
        chk(!lock, "R6", "lock lost at gap two", lock, 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule